// File: doc/BRIEF.md
# Edge-Triggered External Interrupt Controller

The block watches a bank of asynchronous external lines, brings each one into the clock domain, and detects a chosen transition on each line. The transition can be rising, falling or both. When a selected transition arrives on a line that software has enabled, the block sets a pending flag for that line. Each flag stays set until software clears it by writing a one to it.

Request outputs go to the processor's interrupt controller. Each low-numbered line drives a request wire of its own. A contiguous band of higher lines shares one request wire, which is the OR of those lines. Every line in that band keeps its own pending flag, so the handler can read which line fired. A request is the pending flag gated by the enable bit, so disabling a line also withdraws a request that is already latched.

Software reaches four registers through a simple word interface with one register per address. Address 0 is the line enable, address 1 selects rising transitions, address 2 selects falling transitions, and address 3 holds pending status (write one to clear). Bit n of every register belongs to line n.

Top module: `edge_irq_ctrl`

## Requirements
- R1: After reset, all four registers (addresses 0 to 3) read zero and every request output is low.
- R2: With enable bit n and rising-select bit n both set, a low-to-high change on line n sets pending bit n, at the latest four clock cycles after the change.
- R3: With enable bit n and falling-select bit n both set, a high-to-low change on line n sets pending bit n.
- R4: A transition on a line whose enable bit is 0 leaves its pending bit at 0, and that bit stays 0 when the line is enabled later.
- R5: A detected transition on line n sets only bit n of the pending register; the other bits keep their values.
- R6: Writing a 1 to bit n at address 3 clears pending bit n; writing 0 to a bit there leaves it unchanged.
- R7: When a new transition on line n is detected in the same cycle as a write-one-to-clear of bit n, the bit stays set.
- R8: Lines 0 to 4 each drive their own bit of irq_direct (bit n for line n). That bit is high exactly while pending bit n and enable bit n are both 1.
- R9: irq_group is high while any of lines 5 to 9 has both its pending bit and its enable bit set. Each of those lines sets only its own pending bit.
- R10: Clearing an enable bit drops the request of a line that is already pending without clearing its pending bit, and setting the enable bit again raises the request again.
- R11: A line held at a constant level sets no pending bit, and a transition whose direction is not selected for that line sets none.
- R12: Writes to addresses 0, 1 and 2 replace the whole enable, rising-select and falling-select register, take effect at the next clock edge and read back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_in | input | N_LINES | Asynchronous external lines |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register written (0 enable, 1 rising, 2 falling, 3 pending) |
| wr_data | input | N_LINES | Write data, bit n for line n |
| rd_addr | input | 2 | Register read, same encoding as wr_addr |
| rd_data | output | N_LINES | Read data, combinational from rd_addr |
| irq_direct | output | N_DIRECT | Dedicated request per low line |
| irq_group | output | 1 | Shared request of the grouped band |

## Verification
The bench drives single rising transitions on a dedicated line and on each line of the shared band in turn. This confirms that every band member reaches irq_group and that only its own pending bit is set. It drives two band lines at once and clears them one at a time, showing that the shared request stays high until the last one is cleared. It also drives falling transitions with rising select off, levels held without change, and transitions on disabled lines, which separates selected-edge detection from level sensitivity and from enable gating. Finally, it lines up a clear write with a new transition on the same cycle to show that the set wins over the clear.

// File: rtl/edge_irq_pkg.sv
package edge_irq_pkg;

    typedef enum logic [1:0] {
        SEL_ENABLE = 2'd0,
        SEL_RISE   = 2'd1,
        SEL_FALL   = 2'd2,
        SEL_PEND   = 2'd3
    } reg_sel_e;

    function automatic int unsigned band_width(input int unsigned lo, input int unsigned hi);
        return hi - lo + 1;
    endfunction

endpackage

// File: rtl/edge_irq_detect.sv
module edge_irq_detect #(
    parameter int unsigned N_LINES = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] line_in,
    input  logic [N_LINES-1:0] rise_sel,
    input  logic [N_LINES-1:0] fall_sel,
    output logic [N_LINES-1:0] hit
);

    typedef struct packed {
        logic [N_LINES-1:0] meta;
        logic [N_LINES-1:0] cur;
        logic [N_LINES-1:0] prev;
    } det_t;

    det_t st_d, st_q;
    logic [N_LINES-1:0] rose_w, fell_w;

    always_comb begin
        st_d      = st_q;
        st_d.meta = line_in;
        st_d.cur  = st_q.meta;
        st_d.prev = st_q.cur;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar i = 0; i < N_LINES; i++) begin : g_line
        assign rose_w[i] = st_q.cur[i] & ~st_q.prev[i];
        assign fell_w[i] = ~st_q.cur[i] & st_q.prev[i];
        assign hit[i]    = (rise_sel[i] & rose_w[i]) | (fall_sel[i] & fell_w[i]);
    end

    // A hit needs the synchronized level to have moved in the last cycle
    AST_HIT_NEEDS_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (hit & ~(st_q.cur ^ $past(st_q.cur))) == '0); // R11

endmodule

// File: rtl/edge_irq_regs.sv
module edge_irq_regs
    import edge_irq_pkg::*;
#(
    parameter int unsigned N_LINES = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [1:0]         wr_addr,
    input  logic [N_LINES-1:0] wr_data,
    input  logic [1:0]         rd_addr,
    output logic [N_LINES-1:0] rd_data,
    input  logic [N_LINES-1:0] hit,
    output logic [N_LINES-1:0] enable_o,
    output logic [N_LINES-1:0] rise_o,
    output logic [N_LINES-1:0] fall_o,
    output logic [N_LINES-1:0] pend_o
);

    typedef struct packed {
        logic [N_LINES-1:0] enable;
        logic [N_LINES-1:0] rise;
        logic [N_LINES-1:0] fall;
        logic [N_LINES-1:0] pend;
    } regs_t;

    regs_t r_d, r_q;
    logic [N_LINES-1:0] clr_w;
    logic [N_LINES-1:0] set_w;

    always_comb begin
        clr_w = '0;
        set_w = hit & r_q.enable;
        r_d   = r_q;
        if (wr_en) begin
            unique case (reg_sel_e'(wr_addr))
                SEL_ENABLE: r_d.enable = wr_data;
                SEL_RISE:   r_d.rise   = wr_data;
                SEL_FALL:   r_d.fall   = wr_data;
                SEL_PEND:   clr_w      = wr_data;
                default:    ;
            endcase
        end
        r_d.pend = (r_q.pend & ~clr_w) | set_w;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        unique case (reg_sel_e'(rd_addr))
            SEL_ENABLE: rd_data = r_q.enable;
            SEL_RISE:   rd_data = r_q.rise;
            SEL_FALL:   rd_data = r_q.fall;
            SEL_PEND:   rd_data = r_q.pend;
            default:    rd_data = '0;
        endcase
    end

    assign enable_o = r_q.enable;
    assign rise_o   = r_q.rise;
    assign fall_o   = r_q.fall;
    assign pend_o   = r_q.pend;

    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (r_q == '0)); // R1

    AST_MASK_GATES_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.pend & ~$past(r_q.pend) & ~$past(r_q.enable)) == '0); // R4

    AST_SET_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.pend & ~$past(r_q.pend) & ~$past(hit)) == '0); // R5

    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(wr_en && wr_addr == 2'd3) == 1'b1)
            |-> ((r_q.pend & $past(wr_data) & ~$past(hit & r_q.enable)) == '0)); // R6

    AST_UNWRITTEN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(wr_en && wr_addr == 2'd3) == 1'b0)
            |-> (($past(r_q.pend) & ~r_q.pend) == '0)); // R6

    AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(hit & r_q.enable)) & ~r_q.pend) == '0); // R7

endmodule

// File: rtl/edge_irq_fanin.sv
module edge_irq_fanin #(
    parameter int unsigned N_LINES  = 10,
    parameter int unsigned N_DIRECT = 5,
    parameter int unsigned GRP_LO   = 5,
    parameter int unsigned GRP_HI   = 9
) (
    input  logic [N_LINES-1:0]  pend,
    input  logic [N_LINES-1:0]  enable,
    output logic [N_DIRECT-1:0] irq_direct,
    output logic                irq_group
);

    localparam int unsigned GRP_W = edge_irq_pkg::band_width(GRP_LO, GRP_HI);

    logic [N_LINES-1:0] live_w;
    logic [GRP_W-1:0]   band_w;

    assign live_w = pend & enable;

    for (genvar i = 0; i < N_DIRECT; i++) begin : g_direct
        assign irq_direct[i] = live_w[i];
    end

    for (genvar j = 0; j < GRP_W; j++) begin : g_band
        assign band_w[j] = live_w[GRP_LO + j];
    end

    assign irq_group = |band_w;

endmodule

// File: rtl/edge_irq_ctrl.sv
module edge_irq_ctrl #(
    parameter int unsigned N_LINES  = 10,
    parameter int unsigned N_DIRECT = 5,
    parameter int unsigned GRP_LO   = 5,
    parameter int unsigned GRP_HI   = 9
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N_LINES-1:0]  line_in,
    input  logic                wr_en,
    input  logic [1:0]          wr_addr,
    input  logic [N_LINES-1:0]  wr_data,
    input  logic [1:0]          rd_addr,
    output logic [N_LINES-1:0]  rd_data,
    output logic [N_DIRECT-1:0] irq_direct,
    output logic                irq_group
);

    logic [N_LINES-1:0] hit_w, enable_w, rise_w, fall_w, pend_w;

    edge_irq_detect #(.N_LINES(N_LINES)) u_detect (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_in  (line_in),
        .rise_sel (rise_w),
        .fall_sel (fall_w),
        .hit      (hit_w)
    );

    edge_irq_regs #(.N_LINES(N_LINES)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .hit      (hit_w),
        .enable_o (enable_w),
        .rise_o   (rise_w),
        .fall_o   (fall_w),
        .pend_o   (pend_w)
    );

    edge_irq_fanin #(
        .N_LINES  (N_LINES),
        .N_DIRECT (N_DIRECT),
        .GRP_LO   (GRP_LO),
        .GRP_HI   (GRP_HI)
    ) u_fanin (
        .pend       (pend_w),
        .enable     (enable_w),
        .irq_direct (irq_direct),
        .irq_group  (irq_group)
    );

    AST_DIRECT_FANIN: assert property (@(posedge clk) disable iff (!rst_n)
        irq_direct == (pend_w[N_DIRECT-1:0] & enable_w[N_DIRECT-1:0])); // R8

    AST_GROUP_FANIN: assert property (@(posedge clk) disable iff (!rst_n)
        irq_group == (|(pend_w[GRP_HI:GRP_LO] & enable_w[GRP_HI:GRP_LO]))); // R9

    AST_MASK_HIDES_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_direct & ~enable_w[N_DIRECT-1:0]) == '0); // R10

endmodule

// File: tb/edge_irq_ctrl_test.sv
module edge_irq_ctrl_test;

    localparam int CLK_PERIOD = 10;
    localparam int NL = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NL-1:0] line_in = '0;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_addr = '0;
    logic [NL-1:0] wr_data = '0;
    logic [1:0]    rd_addr = '0;
    logic [NL-1:0] rd_data;
    logic [4:0]    irq_direct;
    logic          irq_group;

    edge_irq_ctrl uut (
        .clk(clk), .rst_n(rst_n), .line_in(line_in),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .irq_direct(irq_direct), .irq_group(irq_group)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        string       tag;
        bit          is_reg;
        logic [1:0]  addr;
        logic [15:0] exp;
    } item_t;

    item_t sb_q[$];
    bit    mon_busy = 1'b0;
    int    n_checks = 0;
    int    n_fail = 0;
    bit    finished = 1'b0;

    // monitor: pops one expectation per falling edge and compares
    initial begin
        forever begin
            @(negedge clk);
            if (sb_q.size() != 0) begin
                item_t it;
                logic [15:0] act;
                mon_busy = 1'b1;
                it = sb_q.pop_front();
                if (it.is_reg) rd_addr = it.addr;
                #1;
                act = it.is_reg ? {6'd0, rd_data} : {10'd0, irq_group, irq_direct};
                n_checks++;
                if (act !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
                end
                mon_busy = 1'b0;
            end
        end
    end

    task automatic exp_reg(input string tag, input logic [1:0] a, input logic [NL-1:0] v);
        item_t it;
        it.tag = tag; it.is_reg = 1'b1; it.addr = a; it.exp = {6'd0, v};
        sb_q.push_back(it);
    endtask

    task automatic exp_irq(input string tag, input logic [5:0] v);
        item_t it;
        it.tag = tag; it.is_reg = 1'b0; it.addr = '0; it.exp = {10'd0, v};
        sb_q.push_back(it);
    endtask

    task automatic drain();
        wait (sb_q.size() == 0 && !mon_busy);
        @(negedge clk);
    endtask

    task automatic write_reg(input logic [1:0] a, input logic [NL-1:0] v);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_line(input int n, input logic v);
        @(negedge clk);
        line_in[n] = v;
        repeat (5) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        exp_reg("R1 enable", 2'd0, '0);
        exp_reg("R1 rise", 2'd1, '0);
        exp_reg("R1 fall", 2'd2, '0);
        exp_reg("R1 pending", 2'd3, '0);
        exp_irq("R1 requests", 6'b0);
        drain();

        // R12: configuration registers
        write_reg(2'd0, 10'h3FF);
        write_reg(2'd1, 10'h3FF);
        write_reg(2'd2, 10'h000);
        exp_reg("R12 enable", 2'd0, 10'h3FF);
        exp_reg("R12 rise", 2'd1, 10'h3FF);
        exp_reg("R12 fall", 2'd2, 10'h000);
        drain();

        // R2 R5 R8: rising edge on line 0
        set_line(0, 1'b1);
        exp_reg("R2 R5 pending line0", 2'd3, 10'h001);
        exp_irq("R8 direct line0", 6'b000001);
        drain();

        // R6: write zero keeps, write one clears
        write_reg(2'd3, 10'h000);
        exp_reg("R6 zero write", 2'd3, 10'h001);
        drain();
        write_reg(2'd3, 10'h001);
        exp_reg("R6 one write", 2'd3, 10'h000);
        exp_irq("R6 request gone", 6'b0);
        drain();

        // R11: steady high, then unselected fall
        repeat (6) @(negedge clk);
        exp_reg("R11 level held", 2'd3, 10'h000);
        drain();
        set_line(0, 1'b0);
        exp_reg("R11 unselected fall", 2'd3, 10'h000);
        drain();

        // R9: each band line alone
        for (int n = 5; n <= 9; n++) begin
            set_line(n, 1'b1);
            exp_reg("R9 band pending", 2'd3, 10'(1 << n));
            exp_irq("R9 band request", 6'b100000);
            drain();
            write_reg(2'd3, 10'(1 << n));
            exp_irq("R9 band cleared", 6'b0);
            drain();
            set_line(n, 1'b0);
        end

        // R9: two band lines, cleared one at a time
        @(negedge clk);
        line_in[6] = 1'b1; line_in[8] = 1'b1;
        repeat (5) @(negedge clk);
        exp_reg("R9 two pending", 2'd3, 10'h140);
        drain();
        write_reg(2'd3, 10'h040);
        exp_irq("R9 one left", 6'b100000);
        exp_reg("R9 line8 kept", 2'd3, 10'h100);
        drain();
        write_reg(2'd3, 10'h100);
        exp_irq("R9 none left", 6'b0);
        drain();
        line_in[6] = 1'b0; line_in[8] = 1'b0;
        repeat (5) @(negedge clk);

        // R3: falling select on line 3 only
        write_reg(2'd1, 10'h3F7);
        write_reg(2'd2, 10'h008);
        set_line(3, 1'b1);
        exp_reg("R3 rise unselected", 2'd3, 10'h000);
        drain();
        set_line(3, 1'b0);
        exp_reg("R3 fall sets", 2'd3, 10'h008);
        exp_irq("R3 direct line3", 6'b001000);
        drain();

        // R10: disable hides request, keeps pending
        write_reg(2'd0, 10'h3F7);
        exp_irq("R10 masked request", 6'b0);
        exp_reg("R10 pending kept", 2'd3, 10'h008);
        drain();
        write_reg(2'd0, 10'h3FF);
        exp_irq("R10 request back", 6'b001000);
        drain();
        write_reg(2'd3, 10'h008);

        // R4: disabled line ignores an edge
        write_reg(2'd0, 10'h3EF);
        set_line(4, 1'b1);
        exp_reg("R4 disabled edge", 2'd3, 10'h000);
        drain();
        write_reg(2'd0, 10'h3FF);
        exp_reg("R4 not retroactive", 2'd3, 10'h000);
        exp_irq("R4 no request", 6'b0);
        drain();

        // R7: set and clear in the same cycle
        set_line(2, 1'b1);
        set_line(2, 1'b0);
        exp_reg("R7 setup", 2'd3, 10'h004);
        drain();
        @(negedge clk);
        line_in[2] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 2'd3; wr_data = 10'h004;
        @(negedge clk);
        wr_en = 1'b0;
        exp_reg("R7 set wins", 2'd3, 10'h004);
        drain();
        write_reg(2'd3, 10'h004);
        exp_reg("R7 plain clear", 2'd3, 10'h000);
        drain();

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule